// File: doc/BRIEF.md
# Plug-and-Play Logical Device Configuration Bank

This block holds the resource configuration of several logical devices and lets the host program it through two I/O ports: an index port that selects a register and a data port that reads or writes it. The pair is placed at one of two fixed addresses, picked by a strap input that is sampled while the hardware reset is held. A logical-device-number register, reached through the same pair, chooses which device's registers the indexed accesses reach.

For each device the bank keeps an activate bit, two 16-bit I/O base addresses, an IRQ number with a wake enable, an IRQ type, up to two DMA channels, a device-specific mode byte and a write lock. It drives these settings to the function blocks. While a device is inactive, its base, IRQ and DMA outputs are withheld, and it receives no register-access select. A software reset, triggered through the data port, reloads every unlocked device with its default. The hardware reset reloads everything and clears the locks. Device 3 is a wake-up controller that is always enabled and cannot be reached through the bank.

Top module: `pnp_cfg_bank`

## Requirements
- R1: The index and data ports decode at 002Eh/002Fh when `cfg_strap` was 0 during hardware reset, and at 004Eh/004Fh when it was 1. Changes of `cfg_strap` after reset are ignored, and the unselected pair reads 00h.
- R2: A write to the index port stores the index, and a read of the index port returns it. Index 07h is the logical device number, and it reads back through the data port.
- R3: Index 30h bit 0 activates the selected device. While that bit is clear, `dev_en` is 0, the base and IRQ outputs are 0, both DMA outputs are 4 (no channel), and `dev_sel` stays 0.
- R4: Index 60h/61h hold the high and low bytes of base 0. Index 62h/63h hold the high and low bytes of base 1. Both appear on the base outputs while the device is active.
- R5: Index 70h bits 3:0 hold the IRQ number and bit 4 holds the wake enable. Index 71h bits 1:0 hold the IRQ type. Unused bits read 0.
- R6: Index 74h and 75h bits 2:0 hold the first and second DMA channel. Device 1 has only the first channel, device 2 has both, and devices 0 and 3 have none. An absent channel reads 04h and ignores writes.
- R7: Index F0h is a read/write device mode byte, driven on `dev_mode` at all times.
- R8: Unimplemented indexes read 00h and ignore writes. A device number of 4 or more reaches no registers.
- R9: After hardware reset, device 0 is active with base 0 = 0060h, base 1 = 0064h and IRQ 1. Device 1 is inactive with base 0378h/0778h, IRQ 7 and DMA 3. Device 2 has zero bases, IRQ 0 and DMA 4. Device 3 is enabled, reads 00h and ignores writes.
- R10: A data write to index 02h with bit 1 set resets the device number to 0 and reloads every unlocked device with its hardware reset values.
- R11: Writing 1 to index F1h bit 0 locks the selected device. A locked device ignores all writes and the software reset, and the lock reads back as 01h. Only the hardware reset clears it.
- R12: During an I/O read or write, `dev_sel` asserts the lowest-numbered active device whose nonzero base 0 matches the address above the low 3 bits (8-byte window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| cfg_strap | input | 1 | Selects the configuration port pair, sampled during reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while `io_rd` is high |
| dev_en | output | NUM_DEV | Device enables |
| dev_base0 | output | 16*NUM_DEV | Base address 0 per device |
| dev_base1 | output | 16*NUM_DEV | Base address 1 per device |
| dev_irq | output | 4*NUM_DEV | IRQ number per device |
| dev_irq_type | output | 2*NUM_DEV | IRQ type per device |
| dev_wake | output | NUM_DEV | Wake-on-IRQ enable per device |
| dev_dma0 | output | 3*NUM_DEV | First DMA channel, 4 = none |
| dev_dma1 | output | 3*NUM_DEV | Second DMA channel, 4 = none |
| dev_mode | output | 8*NUM_DEV | Device mode byte |
| dev_sel | output | NUM_DEV | Register-access select per device |

## Verification
Four properties are checked on every cycle. The decode select is at most one-hot and never names a disabled device. A locked device's settings and its lock stay frozen until the hardware reset. A software reset leaves device number 0, and the index register takes each index-port write. The strap choice holds after reset, and reads aimed at the wake-up device return zero. The bench scenarios are needed for the rest: the default values, the byte layout of each index, the absent-DMA and unimplemented-index read values, the reset subsets with and without a lock, and the decode priority when two active devices overlap.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

  typedef struct packed {
    logic        act;
    logic [15:0] base0;
    logic [15:0] base1;
    logic [3:0]  irq;
    logic        wake;
    logic [1:0]  irq_type;
    logic [2:0]  dma0;
    logic [2:0]  dma1;
    logic [7:0]  mode;
  } dev_cfg_t;

  localparam logic [7:0] IX_GCTL = 8'h02;
  localparam logic [7:0] IX_LDN  = 8'h07;
  localparam logic [7:0] IX_ACT  = 8'h30;
  localparam logic [7:0] IX_B0H  = 8'h60;
  localparam logic [7:0] IX_B0L  = 8'h61;
  localparam logic [7:0] IX_B1H  = 8'h62;
  localparam logic [7:0] IX_B1L  = 8'h63;
  localparam logic [7:0] IX_IRQ  = 8'h70;
  localparam logic [7:0] IX_ITYP = 8'h71;
  localparam logic [7:0] IX_DMA0 = 8'h74;
  localparam logic [7:0] IX_DMA1 = 8'h75;
  localparam logic [7:0] IX_MODE = 8'hF0;
  localparam logic [7:0] IX_LOCK = 8'hF1;

  localparam logic [2:0] DMA_NONE = 3'd4;
  localparam int WAKE_DEV = 3;

  // Reset image of one device; legacy devices get their classic resources.
  function automatic dev_cfg_t dev_default(int dev);
    dev_cfg_t c;
    c = '0;
    c.dma0 = DMA_NONE;
    c.dma1 = DMA_NONE;
    case (dev)
      0: begin c.act = 1'b1; c.base0 = 16'h0060; c.base1 = 16'h0064; c.irq = 4'd1; end
      1: begin c.base0 = 16'h0378; c.base1 = 16'h0778; c.irq = 4'd7; c.dma0 = 3'd3; end
      WAKE_DEV: c.act = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

  function automatic int dma_chans(int dev);
    case (dev)
      1: return 1;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] cfg_index_addr(logic strap);
    return strap ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic win_hit(logic [15:0] a, logic [15:0] b, int unsigned wbits);
    return (a >> wbits) == (b >> wbits);
  endfunction

endpackage

// File: rtl/pnp_host_port.sv
module pnp_host_port
  import pnp_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_strap,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  idx_q,
  output logic [7:0]  ldn_q,
  output logic        dat_wr,
  output logic        dat_rd,
  output logic        idx_rd,
  output logic        soft_rst
);

  logic        strap_q;
  logic [15:0] idx_addr;
  logic        hit_idx;
  logic        hit_dat;

  assign idx_addr = cfg_index_addr(strap_q);
  assign hit_idx  = (io_addr == idx_addr);
  assign hit_dat  = (io_addr == idx_addr + 16'd1);
  assign dat_wr   = io_wr & hit_dat;
  assign dat_rd   = io_rd & hit_dat;
  assign idx_rd   = io_rd & hit_idx;
  assign soft_rst = dat_wr & (idx_q == IX_GCTL) & io_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= cfg_strap;
      idx_q   <= '0;
      ldn_q   <= '0;
    end else begin
      if (io_wr && hit_idx) idx_q <= io_wdata;
      if (soft_rst)                          ldn_q <= '0;
      else if (dat_wr && idx_q == IX_LDN)    ldn_q <= io_wdata;
    end
  end

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q)) else $error("strap changed"); // R1
  AST_INDEX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_idx) |=> (idx_q == $past(io_wdata))) else $error("index lost"); // R2
  AST_SOFT_LDN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ldn_q == 8'h00)) else $error("ldn kept"); // R10

endmodule

// File: rtl/pnp_dev_regs.sv
module pnp_dev_regs
  import pnp_cfg_pkg::*;
#(
  parameter int DEV = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        en,
  output logic [15:0] base0_o,
  output logic [15:0] base1_o,
  output logic [3:0]  irq_o,
  output logic        wake_o,
  output logic [1:0]  irq_type_o,
  output logic [2:0]  dma0_o,
  output logic [2:0]  dma1_o,
  output logic [7:0]  mode_o
);

  localparam int       CHANS = dma_chans(DEV);
  localparam dev_cfg_t DFLT  = dev_default(DEV);

  dev_cfg_t cfg_q;
  logic     lock_q;
  logic     wr_ok;
  logic     reload;

  assign wr_ok  = wr_en & ~lock_q;
  assign reload = soft_rst & ~lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= DFLT;
      lock_q <= 1'b0;
    end else if (reload) begin
      cfg_q  <= DFLT;
    end else if (wr_ok) begin
      case (idx)
        IX_ACT:  cfg_q.act         <= wdata[0];
        IX_B0H:  cfg_q.base0[15:8] <= wdata;
        IX_B0L:  cfg_q.base0[7:0]  <= wdata;
        IX_B1H:  cfg_q.base1[15:8] <= wdata;
        IX_B1L:  cfg_q.base1[7:0]  <= wdata;
        IX_IRQ:  begin cfg_q.irq <= wdata[3:0]; cfg_q.wake <= wdata[4]; end
        IX_ITYP: cfg_q.irq_type    <= wdata[1:0];
        IX_DMA0: if (CHANS >= 1) cfg_q.dma0 <= wdata[2:0];
        IX_DMA1: if (CHANS >= 2) cfg_q.dma1 <= wdata[2:0];
        IX_MODE: cfg_q.mode        <= wdata;
        IX_LOCK: if (wdata[0]) lock_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_ACT:  rdata = {7'd0, cfg_q.act};
      IX_B0H:  rdata = cfg_q.base0[15:8];
      IX_B0L:  rdata = cfg_q.base0[7:0];
      IX_B1H:  rdata = cfg_q.base1[15:8];
      IX_B1L:  rdata = cfg_q.base1[7:0];
      IX_IRQ:  rdata = {3'd0, cfg_q.wake, cfg_q.irq};
      IX_ITYP: rdata = {6'd0, cfg_q.irq_type};
      IX_DMA0: rdata = {5'd0, cfg_q.dma0};
      IX_DMA1: rdata = {5'd0, cfg_q.dma1};
      IX_MODE: rdata = cfg_q.mode;
      IX_LOCK: rdata = {7'd0, lock_q};
      default: rdata = 8'h00;
    endcase
  end

  assign en         = cfg_q.act;
  assign base0_o    = cfg_q.act ? cfg_q.base0 : 16'h0000;
  assign base1_o    = cfg_q.act ? cfg_q.base1 : 16'h0000;
  assign irq_o      = cfg_q.act ? cfg_q.irq : 4'd0;
  assign wake_o     = cfg_q.act & cfg_q.wake;
  assign irq_type_o = cfg_q.act ? cfg_q.irq_type : 2'd0;
  assign dma0_o     = cfg_q.act ? cfg_q.dma0 : DMA_NONE;
  assign dma1_o     = cfg_q.act ? cfg_q.dma1 : DMA_NONE;
  assign mode_o     = cfg_q.mode;

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q)) else $error("locked cfg changed"); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q) else $error("lock dropped"); // R11

endmodule

// File: rtl/pnp_io_decode.sv
module pnp_io_decode
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int WIN_BITS = 3
) (
  input  logic [15:0]           io_addr,
  input  logic                  io_cyc,
  input  logic [NUM_DEV-1:0]    dev_en,
  input  logic [NUM_DEV*16-1:0] dev_base0,
  output logic [NUM_DEV-1:0]    dev_sel
);

  localparam logic [NUM_DEV-1:0] LSB_ONE = {{(NUM_DEV-1){1'b0}}, 1'b1};

  logic [NUM_DEV-1:0] hit;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_hit
    assign hit[i] = io_cyc & dev_en[i] & (dev_base0[i*16 +: 16] != 16'h0000)
                  & win_hit(io_addr, dev_base0[i*16 +: 16], WIN_BITS);
  end

  // lowest-numbered hit wins
  assign dev_sel = hit & (~hit + LSB_ONE);

endmodule

// File: rtl/pnp_cfg_bank.sv
module pnp_cfg_bank
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int WIN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_strap,
  input  logic [15:0]           io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic [NUM_DEV-1:0]    dev_en,
  output logic [NUM_DEV*16-1:0] dev_base0,
  output logic [NUM_DEV*16-1:0] dev_base1,
  output logic [NUM_DEV*4-1:0]  dev_irq,
  output logic [NUM_DEV*2-1:0]  dev_irq_type,
  output logic [NUM_DEV-1:0]    dev_wake,
  output logic [NUM_DEV*3-1:0]  dev_dma0,
  output logic [NUM_DEV*3-1:0]  dev_dma1,
  output logic [NUM_DEV*8-1:0]  dev_mode,
  output logic [NUM_DEV-1:0]    dev_sel
);

  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic       dat_wr;
  logic       dat_rd;
  logic       idx_rd;
  logic       soft_rst;
  logic [7:0] dev_rd [NUM_DEV];
  logic [7:0] dev_mux;

  pnp_host_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_strap(cfg_strap),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .idx_q    (idx_q),
    .ldn_q    (ldn_q),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd),
    .idx_rd   (idx_rd),
    .soft_rst (soft_rst)
  );

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    localparam bit HID = (i == WAKE_DEV);
    logic       wr_i;
    logic [7:0] rd_i;

    assign wr_i      = dat_wr & (ldn_q == 8'(i)) & ~HID;
    assign dev_rd[i] = HID ? 8'h00 : rd_i;

    pnp_dev_regs #(.DEV(i)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .wr_en     (wr_i),
      .idx       (idx_q),
      .wdata     (io_wdata),
      .rdata     (rd_i),
      .en        (dev_en[i]),
      .base0_o   (dev_base0[i*16 +: 16]),
      .base1_o   (dev_base1[i*16 +: 16]),
      .irq_o     (dev_irq[i*4 +: 4]),
      .wake_o    (dev_wake[i]),
      .irq_type_o(dev_irq_type[i*2 +: 2]),
      .dma0_o    (dev_dma0[i*3 +: 3]),
      .dma1_o    (dev_dma1[i*3 +: 3]),
      .mode_o    (dev_mode[i*8 +: 8])
    );
  end

  always_comb begin
    dev_mux = 8'h00;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldn_q == 8'(i)) dev_mux = dev_rd[i];
  end

  assign io_rdata = idx_rd ? idx_q :
                    dat_rd ? ((idx_q == IX_LDN) ? ldn_q : dev_mux) : 8'h00;

  pnp_io_decode #(.NUM_DEV(NUM_DEV), .WIN_BITS(WIN_BITS)) u_dec (
    .io_addr  (io_addr),
    .io_cyc   (io_wr | io_rd),
    .dev_en   (dev_en),
    .dev_base0(dev_base0),
    .dev_sel  (dev_sel)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel)) else $error("multiple selects"); // R12
  AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel & ~dev_en) == '0) else $error("select of inactive device"); // R3
  AST_HIDDEN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && ldn_q == 8'(WAKE_DEV) && idx_q != IX_LDN) |-> (io_rdata == 8'h00))
    else $error("hidden device readable"); // R9

endmodule

// File: tb/pnp_cfg_bank_tb.sv
`timescale 1ns/1ps
module pnp_cfg_bank_tb;

  localparam int ND = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_strap = 1'b1;
  logic [15:0]    io_addr = '0;
  logic           io_wr = 1'b0;
  logic           io_rd = 1'b0;
  logic [7:0]     io_wdata = '0;
  logic [7:0]     io_rdata;
  logic [ND-1:0]  dev_en;
  logic [ND*16-1:0] dev_base0, dev_base1;
  logic [ND*4-1:0]  dev_irq;
  logic [ND*2-1:0]  dev_irq_type;
  logic [ND-1:0]    dev_wake;
  logic [ND*3-1:0]  dev_dma0, dev_dma1;
  logic [ND*8-1:0]  dev_mode;
  logic [ND-1:0]    dev_sel;

  int errors = 0;
  int checks = 0;
  logic [15:0] cix = 16'h004E;
  logic [7:0]  rv;
  logic [ND-1:0] last_sel;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pnp_cfg_bank #(.NUM_DEV(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dev_en(dev_en), .dev_base0(dev_base0), .dev_base1(dev_base1),
    .dev_irq(dev_irq), .dev_irq_type(dev_irq_type), .dev_wake(dev_wake),
    .dev_dma0(dev_dma0), .dev_dma1(dev_dma1), .dev_mode(dev_mode), .dev_sel(dev_sel)
  );

  typedef struct packed {
    logic [7:0] ldn;
    logic [7:0] idx;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{8'd0, 8'h30, 1'b0, 8'h00, 8'h01, 8'd9},  // R9 device 0 active
    '{8'd0, 8'h60, 1'b0, 8'h00, 8'h00, 8'd9},  // R9
    '{8'd0, 8'h61, 1'b0, 8'h00, 8'h60, 8'd9},  // R9
    '{8'd0, 8'h63, 1'b0, 8'h00, 8'h64, 8'd9},  // R9
    '{8'd0, 8'h70, 1'b0, 8'h00, 8'h01, 8'd9},  // R9
    '{8'd0, 8'h74, 1'b1, 8'h02, 8'h04, 8'd6},  // R6 absent channel
    '{8'd0, 8'h75, 1'b0, 8'h00, 8'h04, 8'd6},  // R6
    '{8'd0, 8'h60, 1'b1, 8'h12, 8'h12, 8'd4},  // R4
    '{8'd0, 8'h61, 1'b1, 8'h34, 8'h34, 8'd4},  // R4
    '{8'd0, 8'h62, 1'b1, 8'hAB, 8'hAB, 8'd4},  // R4
    '{8'd0, 8'h70, 1'b1, 8'hFF, 8'h1F, 8'd5},  // R5
    '{8'd0, 8'h71, 1'b1, 8'hFF, 8'h03, 8'd5},  // R5
    '{8'd0, 8'h70, 1'b1, 8'h01, 8'h01, 8'd5},  // R5
    '{8'd0, 8'h20, 1'b0, 8'h00, 8'h00, 8'd8},  // R8
    '{8'd0, 8'h40, 1'b1, 8'hAA, 8'h00, 8'd8},  // R8
    '{8'd0, 8'hF2, 1'b1, 8'h55, 8'h00, 8'd8},  // R8
    '{8'd1, 8'h74, 1'b0, 8'h00, 8'h03, 8'd9},  // R9
    '{8'd1, 8'h75, 1'b1, 8'h02, 8'h04, 8'd6},  // R6 single channel
    '{8'd1, 8'h74, 1'b1, 8'h01, 8'h01, 8'd6},  // R6
    '{8'd1, 8'h74, 1'b1, 8'h03, 8'h03, 8'd6},  // R6
    '{8'd1, 8'h30, 1'b0, 8'h00, 8'h00, 8'd3},  // R3
    '{8'd1, 8'hF0, 1'b1, 8'h5A, 8'h5A, 8'd7},  // R7
    '{8'd2, 8'h74, 1'b1, 8'h02, 8'h02, 8'd6},  // R6
    '{8'd2, 8'h75, 1'b1, 8'hFF, 8'h07, 8'd6},  // R6
    '{8'd2, 8'h61, 1'b0, 8'h00, 8'h00, 8'd9},  // R9
    '{8'd2, 8'h07, 1'b0, 8'h00, 8'h02, 8'd2},  // R2
    '{8'd5, 8'h30, 1'b1, 8'h01, 8'h00, 8'd8},  // R8 invalid device number
    '{8'd3, 8'hF0, 1'b1, 8'h77, 8'h00, 8'd9}   // R9 hidden device
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata;
    last_sel = dev_sel;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic sel_dev(input logic [7:0] l);
    io_write(cix, 8'h07);
    io_write(cix + 16'd1, l);
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    io_write(cix, i);
    io_write(cix + 16'd1, d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
    io_write(cix, i);
    io_read(cix + 16'd1, d);
  endtask

  task automatic hw_reset(input logic s);
    @(negedge clk);
    cfg_strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    hw_reset(1'b1);
    @(negedge clk); #1;
    // reset state
    chk("R9 dev_en", dev_en, 4'b1001);
    chk("R9 base0 dev0", dev_base0[15:0], 16'h0060);
    chk("R9 irq dev0", dev_irq[3:0], 4'd1);
    chk("R3 base0 inactive dev1", dev_base0[31:16], 16'h0000);
    chk("R3 dma0 inactive dev1", dev_dma0[5:3], 3'd4);

    // strap sampled at reset only
    cfg_strap = 1'b0;
    io_read(16'h002E, rv);
    chk("R1 unselected pair", rv, 8'h00);
    io_write(cix, 8'h71);
    io_read(cix, rv);
    chk("R2 index readback", rv, 8'h71);

    for (int i = 0; i < NV; i++) begin
      sel_dev(VEC[i].ldn);
      io_write(cix, VEC[i].idx);
      if (VEC[i].wr) io_write(cix + 16'd1, VEC[i].wdata);
      io_read(cix + 16'd1, rv);
      checks++;
      if (rv !== VEC[i].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual %0h expected %0h", VEC[i].req, i, rv, VEC[i].exp);
      end
    end

    // activation of device 1
    sel_dev(8'd1);
    wr_reg(8'h30, 8'h01);
    @(negedge clk); #1;
    chk("R3 dev_en after activate", dev_en, 4'b1011);
    chk("R4 base0 dev1", dev_base0[31:16], 16'h0378);
    chk("R4 base1 dev0", dev_base1[15:0], 16'hAB64);
    chk("R5 irq dev1", dev_irq[7:4], 4'd7);
    chk("R5 type dev0", dev_irq_type[1:0], 2'd3);
    chk("R6 dma0 dev1", dev_dma0[5:3], 3'd3);
    chk("R6 dma1 dev1", dev_dma1[5:3], 3'd4);
    chk("R7 mode dev1", dev_mode[15:8], 8'h5A);

    // decode select
    io_read(16'h1236, rv);
    chk("R12 sel dev0", last_sel, 4'b0001);
    io_read(16'h037F, rv);
    chk("R12 sel dev1", last_sel, 4'b0010);
    io_read(16'h0380, rv);
    chk("R12 outside window", last_sel, 4'b0000);
    chk("R12 no cycle", dev_sel, 4'b0000);
    sel_dev(8'd2);
    wr_reg(8'h60, 8'h12);
    wr_reg(8'h61, 8'h30);
    io_read(16'h1231, rv);
    chk("R3 inactive dev2 no select", last_sel, 4'b0001);
    chk("R3 inactive dev2 base hidden", dev_base0[47:32], 16'h0000);
    wr_reg(8'h30, 8'h01);
    io_read(16'h1231, rv);
    chk("R12 overlap priority", last_sel, 4'b0001);
    sel_dev(8'd0);
    wr_reg(8'h30, 8'h00);
    io_read(16'h1231, rv);
    chk("R12 overlap after dev0 off", last_sel, 4'b0100);
    chk("R3 dev_en", dev_en, 4'b1110);
    chk("R3 irq inactive dev0", dev_irq[3:0], 4'd0);
    chk("R6 dma0 dev2", dev_dma0[8:6], 3'd2);

    // lock and software reset
    sel_dev(8'd2);
    wr_reg(8'hF0, 8'hC3);
    wr_reg(8'hF1, 8'h01);
    rd_reg(8'hF1, rv);
    chk("R11 lock readback", rv, 8'h01);
    sel_dev(8'd1);
    wr_reg(8'h60, 8'h55);
    wr_reg(8'h02, 8'h02);
    rd_reg(8'h07, rv);
    chk("R10 ldn cleared", rv, 8'h00);
    chk("R10 dev_en reload", dev_en, 4'b1101);
    chk("R10 base0 dev0 reload", dev_base0[15:0], 16'h0060);
    sel_dev(8'd1);
    rd_reg(8'h60, rv);
    chk("R10 base0 high dev1 reload", rv, 8'h03);
    sel_dev(8'd2);
    rd_reg(8'hF0, rv);
    chk("R11 locked mode kept", rv, 8'hC3);
    wr_reg(8'hF0, 8'h00);
    rd_reg(8'hF0, rv);
    chk("R11 locked write ignored", rv, 8'hC3);
    chk("R11 locked base kept", dev_base0[47:32], 16'h1230);

    // hardware reset with the other strap
    hw_reset(1'b0);
    cix = 16'h002E;
    sel_dev(8'd2);
    rd_reg(8'hF1, rv);
    chk("R11 lock cleared by hw reset", rv, 8'h00);
    rd_reg(8'hF0, rv);
    chk("R11 mode cleared by hw reset", rv, 8'h00);
    chk("R9 dev_en after hw reset", dev_en, 4'b1001);
    io_read(16'h004E, rv);
    chk("R1 old pair dead", rv, 8'h00);
    io_read(16'h002E, rv);
    chk("R1 new pair index", rv, 8'hF0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule